// File: doc/BRIEF.md
# Dual-Path Registered Bus Transceiver

The block joins two 18-bit buses, A and B, through two independent, non-inverting paths: one carries A towards B and the other carries B towards A. Each path has its own storage word and four control inputs: an active-low output enable, a pass-through (latch) enable, a capture strobe and an active-low strobe enable. A path passes the opposite bus straight to its output while pass-through is on. While pass-through is off, it stores a new word when the strobe rises. At all other times it keeps its stored word. Either path can release its output. A side of the bus is modelled as three separate vectors (incoming data, outgoing data and a per-bit drive enable), so an integrator builds the real tri-state pad around it.

The capture strobes are not clocks. All control inputs are sampled by the one system clock. A strobe rise counts as seen when the strobe is low at one clock edge and high at the next. The word is stored at the clock edge that follows. A flag goes high whenever both paths would drive at once, so that bus fights can be caught at the system level.

Top module: `bus_xcvr_dual`

## Requirements
- R1: While `rst_n` is low at a clock edge, both stored words become zero. The strobe samplers are preset to "high", so a strobe that is already high when reset is released does not count as a rising edge.
- R2: Every bit of `b_oe` equals the inverse of `oe_ab_n`, and every bit of `a_oe` equals the inverse of `oe_ba_n`. Both follow combinationally, and a value of 1 means the bit is driven.
- R3: While a path's pass-through enable is 1, its data output equals the opposite bus input in the same cycle, bit for bit with no inversion. Its stored word also takes that input at every clock edge.
- R4: After the pass-through enable falls, the output shows the word that was on the input at the last clock edge at which the enable was still 1.
- R5: Call the edge at which the strobe is first sampled high edge k, where the strobe was sampled low at edge k-1. If at edge k+1 the pass-through enable is 0 and the strobe enable is 0, the path stores the input present at edge k+1. That word appears on the output after edge k+1.
- R6: If the strobe enable is 1 at edge k+1 while pass-through is 0, the stored word does not change.
- R7: While pass-through is 0 and the strobe stays at one level, the stored word does not change, whatever the input data does.
- R8: The two paths are independent: activity on one path's inputs and controls never changes the other path's stored word or output.
- R9: `bus_contend` is 1 exactly when `oe_ab_n` and `oe_ba_n` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all control inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 18 | Incoming data seen on side A |
| a_out | output | 18 | Data the B-to-A path presents on side A |
| a_oe | output | 18 | Per-bit drive enable for side A |
| b_in | input | 18 | Incoming data seen on side B |
| b_out | output | 18 | Data the A-to-B path presents on side B |
| b_oe | output | 18 | Per-bit drive enable for side B |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| le_ab | input | 1 | A-to-B pass-through enable |
| cp_ab | input | 1 | A-to-B capture strobe |
| ce_ab_n | input | 1 | A-to-B strobe enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| le_ba | input | 1 | B-to-A pass-through enable |
| cp_ba | input | 1 | B-to-A capture strobe |
| ce_ba_n | input | 1 | B-to-A strobe enable, active low |
| bus_contend | output | 1 | Both paths driving at the same time |

## Verification
The bench changes the input data on every cycle around each strobe rise. This exposes a design that stores the word from the detection edge instead of the following edge: its output would lag by one word. It holds the strobe high across the release of reset and pulses it while the strobe enable is high. In both cases a wrong design would load a word where the output must stay put. It drops pass-through while the data keeps moving, which shows whether the stored word trails the input by a cycle. It runs both paths at once with different data to catch crosstalk between the lanes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int NLANE = 2;

  typedef enum logic [1:0] {
    UPD_HOLD    = 2'd0,
    UPD_TRACK   = 2'd1,
    UPD_CAPTURE = 2'd2
  } upd_e;

  // Pass-through wins; a detected strobe rise stores only when enabled.
  function automatic upd_e pick_update(input logic pass, input logic stb_en_n,
                                       input logic rise);
    if (pass)
      return UPD_TRACK;
    else if (rise && !stb_en_n)
      return UPD_CAPTURE;
    else
      return UPD_HOLD;
  endfunction

endpackage

// File: rtl/xcvr_edge_sense.sv
module xcvr_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic smp_now;
  logic smp_old;

  // Both samplers preset high so a strobe already high at release is not an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_now <= 1'b1;
      smp_old <= 1'b1;
    end else begin
      smp_now <= strobe;
      smp_old <= smp_now;
    end
  end

  assign rise = smp_now & ~smp_old;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  upd_e             upd,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else if (upd != UPD_HOLD)
      q <= din;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pass,
  input  logic             strobe,
  input  logic             stb_en_n,
  input  logic             drv_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] den,
  output logic [WIDTH-1:0] held,
  output logic             rise
);
  upd_e upd;

  xcvr_edge_sense u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .rise   (rise)
  );

  assign upd = pick_update(pass, stb_en_n, rise);

  xcvr_store #(.WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd),
    .din   (din),
    .q     (held)
  );

  assign dout = pass ? din : held;
  assign den  = {WIDTH{~drv_n}};
endmodule

// File: rtl/bus_xcvr_dual.sv
module bus_xcvr_dual
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe,
  input  logic             oe_ab_n,
  input  logic             le_ab,
  input  logic             cp_ab,
  input  logic             ce_ab_n,
  input  logic             oe_ba_n,
  input  logic             le_ba,
  input  logic             cp_ba,
  input  logic             ce_ba_n,
  output logic             bus_contend
);
  localparam int LANE_AB = 0;
  localparam int LANE_BA = NLANE - 1;

  logic [WIDTH-1:0] l_din  [NLANE];
  logic [WIDTH-1:0] l_dout [NLANE];
  logic [WIDTH-1:0] l_den  [NLANE];
  logic [WIDTH-1:0] l_held [NLANE];
  logic             l_pass [NLANE];
  logic             l_stb  [NLANE];
  logic             l_en_n [NLANE];
  logic             l_drv_n[NLANE];
  logic             l_rise [NLANE];

  // Named internal events for the checker.
  logic [WIDTH-1:0] store_ab, store_ba;
  logic             rise_ab, rise_ba;

  assign l_din[LANE_AB]   = a_in;
  assign l_pass[LANE_AB]  = le_ab;
  assign l_stb[LANE_AB]   = cp_ab;
  assign l_en_n[LANE_AB]  = ce_ab_n;
  assign l_drv_n[LANE_AB] = oe_ab_n;
  assign l_din[LANE_BA]   = b_in;
  assign l_pass[LANE_BA]  = le_ba;
  assign l_stb[LANE_BA]   = cp_ba;
  assign l_en_n[LANE_BA]  = ce_ba_n;
  assign l_drv_n[LANE_BA] = oe_ba_n;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    xcvr_lane #(.WIDTH(WIDTH)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .pass     (l_pass[g]),
      .strobe   (l_stb[g]),
      .stb_en_n (l_en_n[g]),
      .drv_n    (l_drv_n[g]),
      .din      (l_din[g]),
      .dout     (l_dout[g]),
      .den      (l_den[g]),
      .held     (l_held[g]),
      .rise     (l_rise[g])
    );
  end

  assign b_out    = l_dout[LANE_AB];
  assign b_oe     = l_den[LANE_AB];
  assign a_out    = l_dout[LANE_BA];
  assign a_oe     = l_den[LANE_BA];
  assign store_ab = l_held[LANE_AB];
  assign store_ba = l_held[LANE_BA];
  assign rise_ab  = l_rise[LANE_AB];
  assign rise_ba  = l_rise[LANE_BA];

  assign bus_contend = ~oe_ab_n & ~oe_ba_n;
endmodule

// File: rtl/bus_xcvr_dual_chk.sv
module bus_xcvr_dual_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_oe,
  input logic [WIDTH-1:0] b_oe,
  input logic             oe_ab_n,
  input logic             oe_ba_n,
  input logic             le_ab,
  input logic             le_ba,
  input logic             ce_ab_n,
  input logic             ce_ba_n,
  input logic             bus_contend,
  input logic [WIDTH-1:0] store_ab,
  input logic [WIDTH-1:0] store_ba,
  input logic             rise_ab,
  input logic             rise_ba
);
  // R1
  a_r1_clear: assert property (@(posedge clk)
    !rst_n |=> (store_ab == '0 && store_ba == '0));

  // R2
  a_r2_ab_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_ab_n |-> (b_oe == '0));
  a_r2_ba_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_ba_n |-> (a_oe == '0));

  // R3
  a_r3_track_ab: assert property (@(posedge clk) disable iff (!rst_n)
    le_ab |=> store_ab == $past(a_in));
  a_r3_track_ba: assert property (@(posedge clk) disable iff (!rst_n)
    le_ba |=> store_ba == $past(b_in));

  // R5
  a_r5_capture_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && !ce_ab_n && rise_ab) |=> store_ab == $past(a_in));
  a_r5_capture_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && !ce_ba_n && rise_ba) |=> store_ba == $past(b_in));

  // R6
  a_r6_blocked_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && ce_ab_n) |=> $stable(store_ab));
  a_r6_blocked_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && ce_ba_n) |=> $stable(store_ba));

  // R7
  a_r7_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ab && !rise_ab) |=> $stable(store_ab));
  a_r7_hold_ba: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && !rise_ba) |=> $stable(store_ba));

  // R9
  a_r9_contend: assert property (@(posedge clk) disable iff (!rst_n)
    bus_contend |-> (a_oe[0] && b_oe[0]));
endmodule

bind bus_xcvr_dual bus_xcvr_dual_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .a_in        (a_in),
  .b_in        (b_in),
  .a_oe        (a_oe),
  .b_oe        (b_oe),
  .oe_ab_n     (oe_ab_n),
  .oe_ba_n     (oe_ba_n),
  .le_ab       (le_ab),
  .le_ba       (le_ba),
  .ce_ab_n     (ce_ab_n),
  .ce_ba_n     (ce_ba_n),
  .bus_contend (bus_contend),
  .store_ab    (store_ab),
  .store_ba    (store_ba),
  .rise_ab     (rise_ab),
  .rise_ba     (rise_ba)
);

// File: tb/test_bus_xcvr_dual.sv
module test_bus_xcvr_dual;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic         oe_ab_n = 1'b1, le_ab = 1'b0, cp_ab = 1'b0, ce_ab_n = 1'b0;
  logic         oe_ba_n = 1'b1, le_ba = 1'b0, cp_ba = 1'b0, ce_ba_n = 1'b0;
  logic         bus_contend;

  int    n_chk = 0;
  int    n_err = 0;
  string phase = "R1";

  // reference state per lane: [0] A-to-B, [1] B-to-A
  logic [W-1:0] m_word [2];
  int           m_seen [2];
  int           m_prev [2];

  always #5 clk = ~clk;

  bus_xcvr_dual #(.WIDTH(W)) i_bus_xcvr_dual (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .oe_ab_n(oe_ab_n), .le_ab(le_ab), .cp_ab(cp_ab), .ce_ab_n(ce_ab_n),
    .oe_ba_n(oe_ba_n), .le_ba(le_ba), .cp_ba(cp_ba), .ce_ba_n(ce_ba_n),
    .bus_contend(bus_contend)
  );

  // Reference model: behaviour from the requirements, evaluated at each edge.
  always @(posedge clk) begin
    logic [W-1:0] d [2];
    logic         p [2];
    logic         e [2];
    int           s [2];
    d[0] = a_in;  p[0] = le_ab; e[0] = ce_ab_n; s[0] = cp_ab ? 1 : 0;
    d[1] = b_in;  p[1] = le_ba; e[1] = ce_ba_n; s[1] = cp_ba ? 1 : 0;
    for (int l = 0; l < 2; l++) begin
      if (!rst_n) begin
        m_word[l] = '0;
        m_seen[l] = 1;
        m_prev[l] = 1;
      end else begin
        if (p[l])
          m_word[l] = d[l];
        else if (m_seen[l] == 1 && m_prev[l] == 0 && !e[l])
          m_word[l] = d[l];
        m_prev[l] = m_seen[l];
        m_seen[l] = s[l];
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] e_b, e_a;
    e_b = le_ab ? a_in : m_word[0];
    e_a = le_ba ? b_in : m_word[1];
    chk(phase, "b_out", b_out, e_b);
    chk(phase, "a_out", a_out, e_a);
    chk("R2", "b_oe", b_oe, {W{~oe_ab_n}});
    chk("R2", "a_oe", a_oe, {W{~oe_ba_n}});
    chk("R9", "bus_contend", {{(W-1){1'b0}}, bus_contend},
        {{(W-1){1'b0}}, (~oe_ab_n & ~oe_ba_n)});
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      compare_all();
    end
  endtask

  initial begin
    logic [W-1:0] lfsr;
    // R1: reset with strobe held high across release
    cp_ab = 1'b1; cp_ba = 1'b1; a_in = 18'h2F0F0; b_in = 18'h1234A;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    chk("R1", "b_out after reset", b_out, '0);
    chk("R1", "a_out after reset", a_out, '0);

    // R2 / R9: output enables
    phase = "R2";
    oe_ab_n = 1'b0; tick(1);
    chk("R2", "b_oe on", b_oe, '1);
    phase = "R9";
    oe_ba_n = 1'b0; tick(1);
    chk("R9", "contend set", {{(W-1){1'b0}}, bus_contend}, 18'h1);
    oe_ab_n = 1'b1; tick(1);
    chk("R9", "contend clear", {{(W-1){1'b0}}, bus_contend}, 18'h0);
    oe_ba_n = 1'b1; tick(1);

    // R3: pass-through with several patterns
    phase = "R3";
    cp_ab = 1'b0; cp_ba = 1'b0;
    le_ab = 1'b1; oe_ab_n = 1'b0;
    a_in = 18'h3FFFF; tick(1);
    chk("R3", "pass ones", b_out, 18'h3FFFF);
    a_in = 18'h00000; tick(1);
    a_in = 18'h2AAAA; tick(1);
    chk("R3", "pass 2AAAA", b_out, 18'h2AAAA);
    a_in = 18'h15555; tick(1);

    // R4: drop pass-through while data moves
    phase = "R4";
    le_ab = 1'b0; a_in = 18'h0BEEF; tick(1);
    chk("R4", "holds last passed", b_out, 18'h15555);
    a_in = 18'h3C3C3; tick(2);
    chk("R4", "still held", b_out, 18'h15555);

    // R5: strobe rise, data changes each cycle
    phase = "R5";
    ce_ab_n = 1'b0;
    cp_ab = 1'b1; a_in = 18'h11111; tick(1);
    a_in = 18'h22222; tick(1);
    a_in = 18'h33333; tick(2);
    chk("R5", "captured word after detection", b_out, 18'h22222);
    cp_ab = 1'b0; tick(1);
    cp_ab = 1'b1; a_in = 18'h00001; tick(1);
    a_in = 18'h20000; tick(2);
    chk("R5", "captured edge bits", b_out, 18'h20000);

    // R6: strobe enable blocks capture
    phase = "R6";
    cp_ab = 1'b0; ce_ab_n = 1'b1; tick(1);
    cp_ab = 1'b1; a_in = 18'h0F00F; tick(1);
    a_in = 18'h30FF0; tick(2);
    chk("R6", "blocked capture", b_out, 18'h20000);

    // R7: steady strobe holds while data changes
    phase = "R7";
    ce_ab_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      a_in = 18'h01010 << i; tick(1);
    end
    cp_ab = 1'b0;
    for (int i = 0; i < 3; i++) begin
      a_in = 18'h3FFF0 - i; tick(1);
    end
    chk("R7", "held with steady strobe", b_out, 18'h20000);

    // R8: B-to-A activity leaves A-to-B untouched, and the reverse
    phase = "R8";
    oe_ba_n = 1'b0;
    le_ba = 1'b1; b_in = 18'h0ACE1; tick(1);
    chk("R8", "BA pass", a_out, 18'h0ACE1);
    le_ba = 1'b0; cp_ba = 1'b1; b_in = 18'h12345; tick(3);
    chk("R8", "AB unaffected", b_out, 18'h20000);
    chk("R8", "BA captured", a_out, 18'h12345);
    cp_ba = 1'b0; le_ab = 1'b1; a_in = 18'h0DEAD; tick(2);
    chk("R8", "BA unaffected", a_out, 18'h12345);
    le_ab = 1'b0;

    // R8: mixed pseudo-random activity on both paths
    lfsr = 18'h1ACE5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[16:0], lfsr[17] ^ lfsr[10]};
      a_in = lfsr;
      b_in = {lfsr[8:0], lfsr[17:9]};
      cp_ab = lfsr[0]; cp_ba = lfsr[3];
      le_ab = (lfsr[5:4] == 2'b11); le_ba = (lfsr[7:6] == 2'b11);
      ce_ab_n = lfsr[9] & lfsr[11]; ce_ba_n = lfsr[12] & lfsr[14];
      oe_ab_n = lfsr[2]; oe_ba_n = lfsr[13];
      tick(1);
    end

    // R1: reset mid-run clears both words
    phase = "R1";
    le_ab = 1'b0; le_ba = 1'b0; cp_ab = 1'b1; cp_ba = 1'b1;
    rst_n = 1'b0; tick(1);
    rst_n = 1'b1; tick(2);
    chk("R1", "b_out cleared", b_out, '0);
    chk("R1", "a_out cleared", a_out, '0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule